// File: doc/BRIEF.md
# Per-CPU Priority Interrupt Selector with Critical Steering

This block belongs to one processor. Each cycle it looks at every interrupt source and finds the one that should go to that processor. A source is a candidate when all of these hold: it is pending, it is not masked, it is routed to this processor, and its priority is strictly above the processor's task priority. Among the candidates, the highest priority wins. When two candidates have the same priority, the lower source index wins.

The winner is then compared with the priority of the interrupt the processor is already servicing. If the winner is strictly higher, or nothing is in service, the block raises a request. Each source's destination word has a critical-select bit for this processor. That bit decides which line carries the request: the critical line when the bit is set, the normal line when it is clear. The bit position is the processor-0 position minus the processor number.

A small state machine registers the result. Its states are `ST_IDLE`, `ST_HELD`, `ST_NORM` and `ST_CRIT`:
- `ST_IDLE`: no candidate.
- `ST_HELD`: a candidate exists but is blocked by the in-service level.
- `ST_NORM`: a request is on the normal line.
- `ST_CRIT`: a request is on the critical line.

The next state is chosen again on every cycle from the current inputs, so any state can move to any other. The transitions are:
- `no_cand`: to `ST_IDLE`.
- `blocked`: to `ST_HELD`.
- `raise_norm`: to `ST_NORM`.
- `raise_crit`: to `ST_CRIT`.

The block keeps one in-service level. An acknowledge loads it and an end-of-interrupt clears it.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset:
  - both interrupt lines are low;
  - the selected index reads all ones (none);
  - the task priority register holds all ones, which blocks every priority, including the maximum.
- R2: A source is a candidate only when:
  - its pending bit is 1;
  - its mask bit is 0;
  - bit TGT_BIT0+CPU_ID of its destination word is 1 (bit 7 with the defaults);
  - its priority is strictly greater than the task priority.
- R3: Among the candidates, the one with the greatest priority is selected. On a priority tie, the lowest source index is selected.
- R4: A request is raised only when the selected priority is strictly greater than the in-service priority, or when nothing is in service. Otherwise the index is still reported and both lines stay low.
- R5: Bit CRIT_BIT0-CPU_ID of the selected source's destination word picks the line: when it is 1 the critical line is asserted, otherwise the normal line. That is bit 0 with the defaults; the bit belonging to another processor has no effect. The two lines are never high together.
- R6: The outputs are registered and reflect the inputs of the previous clock edge. A line stays asserted while its source remains eligible and drops on the edge after the source stops being eligible.
- R7: An acknowledge taken while a line is asserted loads the in-service priority with the selected priority. An end-of-interrupt clears the in-service state, and a request it unblocks appears two edges later. If acknowledge and end-of-interrupt arrive together, the acknowledge wins.
- R8: A pulse on the task-priority write strobe loads the new task priority, and that value governs candidacy from the following edge.
- R9: When there is no candidate, the selected index reads all ones (-1) and both lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| src_pending | input | NUM_SRC | pending bitmap |
| src_mask | input | NUM_SRC | mask bit per source (1 = masked) |
| src_prio | input | NUM_SRC*PRIO_W | packed priorities, source i at [i*PRIO_W +: PRIO_W] |
| src_dest | input | NUM_SRC*DEST_W | packed destination words, source i at [i*DEST_W +: DEST_W] |
| tp_wr | input | 1 | task priority write strobe |
| tp_wdata | input | PRIO_W | new task priority |
| ack | input | 1 | processor accepts the asserted request |
| eoi | input | 1 | processor ends the in-service interrupt |
| irq_norm | output | 1 | normal interrupt line |
| irq_crit | output | 1 | critical interrupt line |
| sel_idx | output | IDX_W+1 | selected source, two's complement, all ones = none |

## Verification
The bound checker checks several properties on every cycle:
- The two lines are never both high.
- An all-ones index never comes with a raised line.
- Any reported source was pending, unmasked and above the task priority on the previous edge.
- A critical request always carries this processor's critical bit.
- An accepted acknowledge always leaves an in-service level behind.

Other behaviour only the bench's directed scenarios can show:
- the tie-break order between sources;
- the blocking of a lower source by the in-service level, and its release two edges after an end-of-interrupt;
- the blocking effect of the reset task priority;
- the irrelevance of another processor's critical bit.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HELD = 2'd1,
        ST_NORM = 2'd2,
        ST_CRIT = 2'd3
    } arb_state_e;
endpackage

// File: rtl/arb_elig.sv
module arb_elig #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    parameter int DEST_W  = 8,
    parameter int TGT_BIT = 7
) (
    input  logic [NUM_SRC-1:0]        pending,
    input  logic [NUM_SRC-1:0]        mask,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [NUM_SRC*DEST_W-1:0] dest_flat,
    input  logic [PRIO_W-1:0]         task_prio,
    output logic [NUM_SRC-1:0]        elig
);
    // One qualifier per source: pending, unmasked, routed here, above task level.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [PRIO_W-1:0] p;
        logic              routed;
        assign p      = prio_flat[g*PRIO_W +: PRIO_W];
        assign routed = dest_flat[g*DEST_W + TGT_BIT];
        assign elig[g] = pending[g] & ~mask[g] & routed & (p > task_prio);
    end
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        elig,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      found,
    output logic [IDX_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);
    // Ascending scan; replace only on strictly greater so the lowest index keeps ties.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/arb_svc.sv
module arb_svc #(
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              done,
    input  logic [PRIO_W-1:0] take_prio,
    output logic              busy,
    output logic [PRIO_W-1:0] busy_prio
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            busy_prio <= '0;
        end else if (take) begin
            busy      <= 1'b1;
            busy_prio <= take_prio;
        end else if (done) begin
            busy      <= 1'b0;
            busy_prio <= '0;
        end
    end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    parameter int PRIO_W    = 4,
    parameter int DEST_W    = 8,
    parameter int CPU_ID    = 1,
    parameter int CRIT_BIT0 = 1,
    parameter int TGT_BIT0  = 6,
    parameter int IDX_W     = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_pending,
    input  logic [NUM_SRC-1:0]        src_mask,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [NUM_SRC*DEST_W-1:0] src_dest,
    input  logic                      tp_wr,
    input  logic [PRIO_W-1:0]         tp_wdata,
    input  logic                      ack,
    input  logic                      eoi,
    output logic                      irq_norm,
    output logic                      irq_crit,
    output logic [IDX_W:0]            sel_idx
);
    localparam int CRIT_BIT = CRIT_BIT0 - CPU_ID;
    localparam int TGT_BIT  = TGT_BIT0 + CPU_ID;

    logic [PRIO_W-1:0] tp_q;
    logic [NUM_SRC-1:0] elig;
    logic               found;
    logic [IDX_W-1:0]   win_idx;
    logic [PRIO_W-1:0]  win_prio;
    logic               svc_busy;
    logic [PRIO_W-1:0]  svc_prio;
    logic               win_crit;
    logic               beats_svc;
    logic               take;

    arb_state_e         state_q, state_d;
    logic [IDX_W-1:0]   sel_q;
    logic [PRIO_W-1:0]  sel_prio_q;

    // Task priority register: resets to the blocking (all ones) level.
    always_ff @(posedge clk) begin
        if (!rst_n)     tp_q <= '1;
        else if (tp_wr) tp_q <= tp_wdata;
    end

    arb_elig #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DEST_W(DEST_W), .TGT_BIT(TGT_BIT)
    ) u_elig (
        .pending  (src_pending),
        .mask     (src_mask),
        .prio_flat(src_prio),
        .dest_flat(src_dest),
        .task_prio(tp_q),
        .elig     (elig)
    );

    arb_pick #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
    ) u_pick (
        .elig     (elig),
        .prio_flat(src_prio),
        .found    (found),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    assign take = ack && (state_q == ST_NORM || state_q == ST_CRIT);

    arb_svc #(.PRIO_W(PRIO_W)) u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .done     (eoi),
        .take_prio(sel_prio_q),
        .busy     (svc_busy),
        .busy_prio(svc_prio)
    );

    assign win_crit  = src_dest[int'(win_idx)*DEST_W + CRIT_BIT];
    assign beats_svc = !svc_busy || (win_prio > svc_prio);

    // Next-state choice: no_cand / blocked / raise_norm / raise_crit.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_HELD, ST_NORM, ST_CRIT: begin
                if (!found)          state_d = ST_IDLE;
                else if (!beats_svc) state_d = ST_HELD;
                else if (win_crit)   state_d = ST_CRIT;
                else                 state_d = ST_NORM;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register together with the registered selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sel_q      <= '0;
            sel_prio_q <= '0;
        end else begin
            state_q    <= state_d;
            sel_q      <= found ? win_idx  : '0;
            sel_prio_q <= found ? win_prio : '0;
        end
    end

    // Output decode from state.
    always_comb begin
        irq_norm = 1'b0;
        irq_crit = 1'b0;
        sel_idx  = '1;
        unique case (state_q)
            ST_IDLE: sel_idx = '1;
            ST_HELD: sel_idx = {1'b0, sel_q};
            ST_NORM: begin irq_norm = 1'b1; sel_idx = {1'b0, sel_q}; end
            ST_CRIT: begin irq_crit = 1'b1; sel_idx = {1'b0, sel_q}; end
            default: sel_idx = '1;
        endcase
    end
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
    parameter int NUM_SRC  = 16,
    parameter int PRIO_W   = 4,
    parameter int DEST_W   = 8,
    parameter int CRIT_BIT = 0,
    parameter int IDX_W    = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      irq_norm,
    input logic                      irq_crit,
    input logic [IDX_W:0]            sel_idx,
    input logic [NUM_SRC-1:0]        src_pending,
    input logic [NUM_SRC-1:0]        src_mask,
    input logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input logic [NUM_SRC*DEST_W-1:0] src_dest,
    input logic [PRIO_W-1:0]         tp_q,
    input logic                      ack,
    input logic                      svc_busy
);
    logic [NUM_SRC-1:0]        prev_pend, prev_mask;
    logic [NUM_SRC*PRIO_W-1:0] prev_prio;
    logic [NUM_SRC*DEST_W-1:0] prev_dest;
    logic [PRIO_W-1:0]         prev_tp;
    logic                      sel_ok;
    logic [IDX_W-1:0]          si;

    always_ff @(posedge clk) begin
        prev_pend <= src_pending;
        prev_mask <= src_mask;
        prev_prio <= src_prio;
        prev_dest <= src_dest;
        prev_tp   <= tp_q;
    end

    assign sel_ok = !sel_idx[IDX_W];
    assign si     = sel_idx[IDX_W-1:0];

    p_one_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_norm && irq_crit));

    p_none_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_idx[IDX_W] |-> (!irq_norm && !irq_crit));

    p_sel_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ok |-> (prev_pend[si] && !prev_mask[si]
                    && prev_prio[int'(si)*PRIO_W +: PRIO_W] > prev_tp));

    p_crit_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_crit |-> prev_dest[int'(si)*DEST_W + CRIT_BIT]);

    p_norm_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm |-> !prev_dest[int'(si)*DEST_W + CRIT_BIT]);

    p_ack_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (irq_norm || irq_crit)) |=> svc_busy);
endmodule

bind prio_irq_arbiter arb_chk #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DEST_W(DEST_W),
    .CRIT_BIT(CRIT_BIT), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_norm(irq_norm), .irq_crit(irq_crit),
    .sel_idx(sel_idx), .src_pending(src_pending), .src_mask(src_mask),
    .src_prio(src_prio), .src_dest(src_dest), .tp_q(tp_q), .ack(ack),
    .svc_busy(svc_busy)
);

// File: tb/prio_irq_arbiter_test.sv
module prio_irq_arbiter_test;
    localparam int NS = 16;
    localparam logic [7:0] TGT   = 8'h80;  // route-to-CPU1 bit 7
    localparam logic [7:0] CRT   = 8'h01;  // CPU1 critical bit 0
    localparam logic [7:0] CRT0  = 8'h02;  // CPU0 critical bit 1
    localparam logic [4:0] NONE  = 5'h1F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]   pend = '0, msk = '0;
    logic [NS*4-1:0] prio = '0;
    logic [NS*8-1:0] dest = '0;
    logic tp_wr = 1'b0, ack = 1'b0, eoi = 1'b0;
    logic [3:0] tp_wdata = '0;
    logic irq_norm, irq_crit;
    logic [4:0] sel_idx;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    prio_irq_arbiter uut (
        .clk(clk), .rst_n(rst_n), .src_pending(pend), .src_mask(msk),
        .src_prio(prio), .src_dest(dest), .tp_wr(tp_wr), .tp_wdata(tp_wdata),
        .ack(ack), .eoi(eoi), .irq_norm(irq_norm), .irq_crit(irq_crit),
        .sel_idx(sel_idx)
    );

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_out(string req, bit n, bit c, logic [4:0] s);
        chk({req, " norm"}, 32'(irq_norm), 32'(n));
        chk({req, " crit"}, 32'(irq_crit), 32'(c));
        chk({req, " idx"},  32'(sel_idx),  32'(s));
    endtask

    task automatic set_src(int i, bit p, int pr, bit m, logic [7:0] d);
        pend[i] = p;
        msk[i]  = m;
        prio[i*4 +: 4] = 4'(pr);
        dest[i*8 +: 8] = d;
    endtask

    task automatic clear_all();
        pend = '0; msk = '0; prio = '0; dest = '0;
    endtask

    task automatic t_reset();
        chk_out("R1 reset", 0, 0, NONE);
        set_src(3, 1, 15, 0, TGT);
        step();
        chk_out("R1 task prio blocks max", 0, 0, NONE);
    endtask

    task automatic t_taskprio();
        tp_wdata = 4'd2; tp_wr = 1'b1;
        step();
        tp_wr = 1'b0;
        step();
        chk_out("R8 write unblocks", 1, 0, 5'd3);
        clear_all();
        set_src(4, 1, 2, 0, TGT);
        step();
        chk_out("R2 equal to task prio", 0, 0, NONE);
        chk_out("R9 none", 0, 0, NONE);
        clear_all();
    endtask

    task automatic t_priority();
        set_src(5, 1, 7, 0, TGT);
        set_src(2, 1, 7, 0, TGT);
        set_src(9, 1, 9, 1, TGT);
        step();
        chk_out("R3 tie lowest index", 1, 0, 5'd2);
        msk[9] = 1'b0;
        step();
        chk_out("R3 highest wins", 1, 0, 5'd9);
        dest[9*8 +: 8] = 8'h00;
        step();
        chk_out("R2 not routed", 1, 0, 5'd2);
        clear_all();
    endtask

    task automatic t_crit();
        set_src(6, 1, 5, 0, TGT | CRT);
        step();
        chk_out("R5 critical", 0, 1, 5'd6);
        dest[6*8 +: 8] = TGT | CRT0;
        step();
        chk_out("R5 other cpu bit", 1, 0, 5'd6);
        clear_all();
    endtask

    task automatic t_hold();
        set_src(11, 1, 6, 0, TGT);
        step(3);
        chk_out("R6 held", 1, 0, 5'd11);
        pend[11] = 1'b0;
        step();
        chk_out("R6 drop", 0, 0, NONE);
        clear_all();
    endtask

    task automatic t_service();
        set_src(4, 1, 8, 0, TGT);
        set_src(6, 1, 5, 0, TGT);
        step();
        chk_out("R4 raise free", 1, 0, 5'd4);
        ack = 1'b1; pend[4] = 1'b0;
        step();
        ack = 1'b0;
        step();
        chk_out("R4 blocked by service", 0, 0, 5'd6);
        set_src(7, 1, 10, 0, TGT);
        step();
        chk_out("R4 above service", 1, 0, 5'd7);
        pend[7] = 1'b0;
        step();
        chk_out("R7 lower still blocked", 0, 0, 5'd6);
        eoi = 1'b1;
        step();
        eoi = 1'b0;
        step();
        chk_out("R7 eoi releases", 1, 0, 5'd6);
        ack = 1'b1; eoi = 1'b1;
        step();
        ack = 1'b0; eoi = 1'b0;
        step();
        chk_out("R7 ack wins over eoi", 0, 0, 5'd6);
        clear_all();
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_taskprio();
        t_priority();
        t_crit();
        t_hold();
        t_service();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule